// File: doc/BRIEF.md
# Three-Pin GPIO Controller with Edge Interrupt

This block controls three general-purpose pins through a parallel byte-wide register port. Software sets each pin as an input or an output, sets the level driven on output pins, and reads back the pin state. Any input pin can be set as an interrupt source. It then reports either a rising or a falling edge on one shared active-low interrupt line.

Input pins pass through a two-flop synchronizer. A captured edge stays latched until software reads the state register. That read clears every captured edge and rearms the detectors. The block drives the output-data and output-enable controls of three tri-state pads. Every register uses bits 7:5, and the pin number equals the bit position.

Top module: `gpio_edge_irq`

## Requirements
- R1: After reset, the direction register reads 0xE0 (all inputs), the enable and polarity registers read 0x00, pad_oe is 000 and irq_n is 1.
- R2: The direction register at address 0x04 takes bits 7:5. A 1 makes a pin an input and a 0 makes it an output. pad_oe[i] is 1 exactly when pin 5+i is an output, from the cycle after the write.
- R3: For an output pin, the value written to bit 5+i of the state register at 0x03 drives pad_out[i] from the next cycle. A read of that bit returns the written value, whatever level is on pad_in.
- R4: For an input pin, a read of the state register returns the pad_in level sampled through two flops. A change becomes visible two clock edges after it is applied.
- R5: With the polarity bit 0 (polarity register 0x06), a rising edge on an input pin whose enable bit is 1 (enable register 0x05) drives irq_n low on the third clock edge after the pad changes.
- R6: With the polarity bit 1, only a falling edge triggers an interrupt. An edge in the other direction leaves irq_n at 1.
- R7: An edge on a pin set as an output, or on a pin whose enable bit is 0, never drives irq_n low.
- R8: A captured edge keeps irq_n low until the state register is read. After that read, irq_n returns to 1 from the next cycle unless a new edge is captured.
- R9: If an edge is captured in the same cycle as a state-register read, the edge wins and irq_n stays low.
- R10: Bits 4:0 of every register read as 0 and ignore writes. A read of any address other than 0x03 to 0x06 returns 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 8 | Register address |
| wr_en | input | 1 | Write strobe, one cycle per write |
| rd_en | input | 1 | Read strobe; a read of the state register clears captured edges |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid combinationally while rd_en is high |
| pad_in | input | 3 | Pad input levels, bit i is pin 5+i |
| pad_out | output | 3 | Output level for each pad |
| pad_oe | output | 3 | Output enable for each pad, 1 drives the pad |
| irq_n | output | 1 | Shared interrupt, active low |

## Verification
A lost or stuck captured-edge flag shows on irq_n. An edge that is missed leaves the line high on the third cycle after the pad change. A flag that is not cleared keeps the line low on the cycle after a state read. A wrong direction bit appears at once on pad_oe, and it changes whether a state read returns the pad level or the written level. A synchronizer with the wrong depth moves both the read-back and the interrupt by one cycle. The bench samples both at exact cycle offsets, so it would see such a shift.

// File: rtl/gpio_edge_pkg.sv
`timescale 1ns/1ps
package gpio_edge_pkg;
  localparam int NPIN    = 3;
  localparam int PIN_LSB = 5;
  localparam int DW      = 8;
  localparam int AW      = 8;
  localparam logic [AW-1:0] ADDR_STATE = 8'h03;
  localparam logic [AW-1:0] ADDR_DIR   = 8'h04;
  localparam logic [AW-1:0] ADDR_EN    = 8'h05;
  localparam logic [AW-1:0] ADDR_POL   = 8'h06;

  // polarity 0: rising edge qualifies; polarity 1: falling edge qualifies
  function automatic logic [NPIN-1:0] edge_hit_f(input logic [NPIN-1:0] cur,
                                                 input logic [NPIN-1:0] prev,
                                                 input logic [NPIN-1:0] pol);
    return (cur & ~prev & ~pol) | (~cur & prev & pol);
  endfunction

  // inputs show the synchronized pad, outputs show the written value
  function automatic logic [NPIN-1:0] state_view_f(input logic [NPIN-1:0] dir,
                                                   input logic [NPIN-1:0] pin,
                                                   input logic [NPIN-1:0] out);
    return (dir & pin) | (~dir & out);
  endfunction
endpackage

// File: rtl/gpio_sync.sv
`timescale 1ns/1ps
module gpio_sync #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_in,
  output logic [W-1:0] d_out
);
  logic [W-1:0] stage1;
  logic [W-1:0] stage2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= '0;
      stage2 <= '0;
    end else begin
      stage1 <= d_in;
      stage2 <= stage1;
    end
  end

  assign d_out = stage2;
endmodule

// File: rtl/gpio_edge_det.sv
`timescale 1ns/1ps
module gpio_edge_det
  import gpio_edge_pkg::*;
#(
  parameter int W = NPIN
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] cur,
  input  logic [W-1:0] qual,
  input  logic [W-1:0] pol,
  input  logic         clr,
  output logic [W-1:0] hit,
  output logic [W-1:0] flag
);
  logic [W-1:0] prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= '0;
    else        prev <= cur;
  end

  assign hit = edge_hit_f(cur, prev, pol) & qual;

  for (genvar i = 0; i < W; i++) begin : g_cap
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      flag[i] <= 1'b0;
      else if (hit[i]) flag[i] <= 1'b1;
      else if (clr)    flag[i] <= 1'b0;
    end
  end

  // R7: a flag may only rise on a pin that was an enabled input
  assert_flag_qualified_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((flag & ~$past(flag) & ~$past(qual)) == '0));
  // R8: a clear with no new edge empties all flags
  assert_clear_empties_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && (hit == '0)) |=> (flag == '0));
  // R9: an edge that coincides with a clear stays captured
  assert_edge_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && (hit != '0)) |=> ((flag & $past(hit)) == $past(hit)));
endmodule

// File: rtl/gpio_regs.sv
`timescale 1ns/1ps
module gpio_regs
  import gpio_edge_pkg::*;
#(
  parameter int W   = NPIN,
  parameter int LSB = PIN_LSB,
  parameter int D   = DW,
  parameter int A   = AW
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [A-1:0] addr,
  input  logic         wr_en,
  input  logic         rd_en,
  input  logic [D-1:0] wdata,
  input  logic [W-1:0] pin_sync,
  output logic [D-1:0] rdata,
  output logic [W-1:0] dir,
  output logic [W-1:0] out,
  output logic [W-1:0] en,
  output logic [W-1:0] pol,
  output logic         state_rd
);
  logic [W-1:0] wfield;
  logic [W-1:0] rfield;
  logic         rhit;

  assign wfield = wdata[LSB +: W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir <= '1;
      out <= '0;
      en  <= '0;
      pol <= '0;
    end else if (wr_en) begin
      case (addr)
        ADDR_STATE: out <= wfield;
        ADDR_DIR:   dir <= wfield;
        ADDR_EN:    en  <= wfield;
        ADDR_POL:   pol <= wfield;
        default: ;
      endcase
    end
  end

  always_comb begin
    rfield = '0;
    rhit   = 1'b1;
    case (addr)
      ADDR_STATE: rfield = state_view_f(dir, pin_sync, out);
      ADDR_DIR:   rfield = dir;
      ADDR_EN:    rfield = en;
      ADDR_POL:   rfield = pol;
      default:    rhit   = 1'b0;
    endcase
    rdata = '0;
    if (rd_en && rhit) rdata[LSB +: W] = rfield;
  end

  assign state_rd = rd_en && (addr == ADDR_STATE);

  // R10: low bits never carry data
  always_comb assert_low_bits_zero_R10: assert (rdata[LSB-1:0] == '0);
endmodule

// File: rtl/gpio_edge_irq.sv
`timescale 1ns/1ps
module gpio_edge_irq
  import gpio_edge_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [AW-1:0]   addr,
  input  logic            wr_en,
  input  logic            rd_en,
  input  logic [DW-1:0]   wdata,
  output logic [DW-1:0]   rdata,
  input  logic [NPIN-1:0] pad_in,
  output logic [NPIN-1:0] pad_out,
  output logic [NPIN-1:0] pad_oe,
  output logic            irq_n
);
  logic [NPIN-1:0] pin_sync;
  logic [NPIN-1:0] dir, out, en, pol;
  logic [NPIN-1:0] hit_w, flag_w;
  logic            state_rd;

  gpio_sync #(.W(NPIN)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_in(pad_in), .d_out(pin_sync)
  );

  gpio_regs #(.W(NPIN), .LSB(PIN_LSB), .D(DW), .A(AW)) u_regs (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .pin_sync(pin_sync), .rdata(rdata),
    .dir(dir), .out(out), .en(en), .pol(pol), .state_rd(state_rd)
  );

  gpio_edge_det #(.W(NPIN)) u_edge (
    .clk(clk), .rst_n(rst_n), .cur(pin_sync), .qual(dir & en), .pol(pol),
    .clr(state_rd), .hit(hit_w), .flag(flag_w)
  );

  assign pad_out = out;
  assign pad_oe  = ~dir;
  assign irq_n   = ~|(flag_w & en);

  // R2: a direction write sets the pad enables on the next cycle
  assert_dir_to_oe_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == ADDR_DIR) |=> (pad_oe == ~$past(wdata[PIN_LSB +: NPIN])));
  // R3: a state write sets the pad level on the next cycle
  assert_state_to_pad_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == ADDR_STATE) |=> (pad_out == $past(wdata[PIN_LSB +: NPIN])));
  // R5: a captured edge pulls the interrupt low unless the enables change at the same time
  assert_edge_irq_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((hit_w != '0) && !wr_en) |=> !irq_n);
endmodule

// File: tb/gpio_edge_irq_tb.sv
`timescale 1ns/1ps
module gpio_edge_irq_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] addr = '0;
  logic       wr_en = 1'b0;
  logic       rd_en = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic [2:0] pad_in = '0;
  logic [2:0] pad_out, pad_oe;
  logic       irq_n;
  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  gpio_edge_irq u_dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .rdata(rdata), .pad_in(pad_in), .pad_out(pad_out),
    .pad_oe(pad_oe), .irq_n(irq_n)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // all tasks start and end just after a falling edge
  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    addr = a; rd_en = 1'b1;
    #1 d = rdata;
    @(posedge clk); @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [7:0] exp_state(input logic [2:0] dir, input logic [2:0] pin,
                                           input logic [2:0] out);
    logic [7:0] v;
    v = 8'h00;
    for (int i = 0; i < 3; i++) v[5+i] = dir[i] ? pin[i] : out[i];
    return v;
  endfunction

  function automatic logic exp_irq_n(input logic [2:0] dir, input logic [2:0] en,
                                     input logic [2:0] pol, input logic [2:0] p0,
                                     input logic [2:0] p1);
    logic any;
    any = 1'b0;
    for (int i = 0; i < 3; i++)
      if (dir[i] && en[i] && (p0[i] != p1[i]) && (p1[i] == !pol[i])) any = 1'b1;
    return !any;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] d;
    logic [2:0] rdir, ren, rpol, rout, p0, p1;
    void'($urandom(32'h5EED1234));
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    idle(1);

    // R1 reset state
    chk("R1 oe", {5'd0, pad_oe}, 8'h00);
    chk("R1 irq", {7'd0, irq_n}, 8'h01);
    rd(8'h04, d); chk("R1 dir", d, 8'hE0);
    rd(8'h05, d); chk("R1 en", d, 8'h00);
    rd(8'h06, d); chk("R1 pol", d, 8'h00);

    // R10 low bits and unmapped addresses
    wr(8'h05, 8'h1F); rd(8'h05, d); chk("R10 low bits ignored", d, 8'h00);
    rd(8'h07, d); chk("R10 addr 07", d, 8'h00);
    rd(8'h00, d); chk("R10 addr 00", d, 8'h00);

    // R2 and R3: pins 5 and 7 as outputs
    wr(8'h04, 8'h5F);
    chk("R2 oe", {5'd0, pad_oe}, 8'h05);
    wr(8'h03, 8'hA0);
    chk("R3 pad_out", {5'd0, pad_out}, 8'h05);
    pad_in = 3'b010; idle(3);
    rd(8'h03, d); chk("R3 output readback", d, 8'hA0 | 8'h40);
    pad_in = 3'b000; idle(3);
    rd(8'h03, d); chk("R3/R4 pin6 low", d, 8'hA0);

    // R4 latency: visible after two edges, not after one
    wr(8'h04, 8'hE0);
    pad_in = 3'b100; idle(1);
    rd(8'h03, d); chk("R4 not yet", d, 8'h00);
    rd(8'h03, d); chk("R4 visible", d, 8'h80);
    pad_in = 3'b000; idle(3); rd(8'h03, d);

    // R5 rising edge on pin 7, timing and latching; R8 clear on read
    wr(8'h06, 8'h00); wr(8'h05, 8'h80); rd(8'h03, d);
    pad_in = 3'b100;
    @(posedge clk); @(posedge clk); @(negedge clk);
    chk("R5 not before 3rd edge", {7'd0, irq_n}, 8'h01);
    idle(1);
    chk("R5 irq low", {7'd0, irq_n}, 8'h00);
    idle(5);
    chk("R8 latched", {7'd0, irq_n}, 8'h00);
    rd(8'h05, d);
    chk("R8 other read keeps", {7'd0, irq_n}, 8'h00);
    rd(8'h03, d);
    chk("R8 cleared", {7'd0, irq_n}, 8'h01);

    // R6 falling polarity on pin 7
    wr(8'h06, 8'h80);
    pad_in = 3'b000; idle(4);
    chk("R6 falling fires", {7'd0, irq_n}, 8'h00);
    rd(8'h03, d);
    pad_in = 3'b100; idle(4);
    chk("R6 rising ignored", {7'd0, irq_n}, 8'h01);

    // R7 output pin and disabled pin
    wr(8'h06, 8'h00); wr(8'h05, 8'hE0); wr(8'h04, 8'hC0);
    pad_in = 3'b101; idle(4);
    chk("R7 output pin", {7'd0, irq_n}, 8'h01);
    wr(8'h04, 8'hE0); wr(8'h05, 8'h80); rd(8'h03, d);
    pad_in = 3'b111; idle(4);
    chk("R7 disabled pin", {7'd0, irq_n}, 8'h01);

    // R9 edge coincides with state read
    pad_in = 3'b000; idle(4); rd(8'h03, d);
    pad_in = 3'b100;
    @(posedge clk); @(posedge clk); @(negedge clk);
    rd(8'h03, d);
    chk("R9 edge wins", {7'd0, irq_n}, 8'h00);
    rd(8'h03, d);
    chk("R9 later read clears", {7'd0, irq_n}, 8'h01);

    // random mix of direction, enable, polarity and pin changes (R4 R5 R6 R7)
    for (int it = 0; it < 200; it++) begin
      rdir = 3'($urandom); ren = 3'($urandom); rpol = 3'($urandom);
      rout = 3'($urandom); p0 = 3'($urandom); p1 = 3'($urandom);
      wr(8'h04, {rdir, 5'h00}); wr(8'h05, {ren, 5'h00});
      wr(8'h06, {rpol, 5'h00}); wr(8'h03, {rout, 5'h00});
      pad_in = p0; idle(4);
      rd(8'h03, d); chk("R4 random state", d, exp_state(rdir, p0, rout));
      chk("R2 random oe", {5'd0, pad_oe}, {5'd0, ~rdir});
      pad_in = p1; idle(4);
      chk("R5 random irq", {7'd0, irq_n}, {7'd0, exp_irq_n(rdir, ren, rpol, p0, p1)});
      rd(8'h03, d);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule